// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block turns the system clock into the timing grid that an I2C bit engine uses to drive SCL. A 7-bit baud value holds two fields. A four-bit multiplier M sets a linear prescaler that divides by M+1. A three-bit exponent N sets a binary stage that divides by 2^(N+1). Each output pulse of the binary stage ends one sub-phase, and ten sub-phases make one SCL period. One SCL period is therefore 10·(M+1)·2^(N+1) system clocks, so the slowest setting (M=15, N=7) gives 40960 clocks per period.

Across a period, SCL is low for five sub-phases and high for five. The block marks four points in each period with single-cycle pulses: the middle of the low half, the rising edge, the middle of the high half and the falling edge. The bit engine changes SDA at the first of these points and samples it at the third.

Writing a baud value, or dropping the enable, zeroes every counter. While the hold input is high, nothing advances. The bit engine raises hold when it stretches SCL itself, or when it sees a slave keeping SCL low.

Top module: `scl_rate_div`

## Requirements
- R1: While reset is asserted and right after it, `sub_tick`, `scl_hi` and all four phase pulses are 0. The stored baud value resets to 0, which gives 2 clocks per sub-phase.
- R2: With M = baud[6:3] and N = baud[2:0], successive `sub_tick` pulses are exactly (M+1)·2^(N+1) clocks apart. This holds for every legal M (0..15) and N (0..7).
- R3: When a restart clock edge leaves all counters at zero, the first `sub_tick` appears (M+1)·2^(N+1) clocks after that edge.
- R4: Number the sub-phases 0..9, starting after a restart. Sub-phase k begins with the k-th `sub_tick` and sub-phase 0 follows the tenth. `scl_hi` is 0 in sub-phases 0..4 and 1 in sub-phases 5..9.
- R5: A phase pulse comes only together with `sub_tick`, and no more than one at a time. `ph_low_mid` marks entry to sub-phase 2, `ph_rise` entry to 5, `ph_high_mid` entry to 7 and `ph_fall` entry to 0.
- R6: A cycle with `baud_we` high loads `baud_wdata` and zeroes all counters at that clock edge. In the next cycle `scl_hi` and every pulse output are 0, whatever the sequence position was before.
- R7: While `en` is low, the counters stay at zero and every output stays 0. The restart timing of R3 applies from the first edge at which `en` is high again.
- R8: While `scl_hold` is high, no counter advances, no `sub_tick` or phase pulse appears, and `scl_hi` keeps its value. When hold is released, timing continues where it stopped, so each held edge delays the next tick by one clock.
- R9: At the slowest setting (baud 7'h7F), sub-phases are 4096 clocks long with no counter wrap error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Divider enable; low holds everything at zero |
| baud_we | input | 1 | Baud write strobe; loads the value and restarts |
| baud_wdata | input | 7 | New baud value: M in [6:3], N in [2:0] |
| scl_hold | input | 1 | Freeze request during SCL stretching |
| sub_tick | output | 1 | One-cycle pulse at the start of each sub-phase |
| scl_hi | output | 1 | Intended SCL level (1 = released high) |
| ph_low_mid | output | 1 | Pulse at the middle of the low half |
| ph_rise | output | 1 | Pulse where SCL rises |
| ph_high_mid | output | 1 | Pulse at the middle of the high half |
| ph_fall | output | 1 | Pulse where SCL falls |

## Verification
A prescaler that stops one count early or late changes the `sub_tick` spacing. That shows on the first tick after a baud write, within one sub-phase. A wrong limit mask in the binary stage shows only for some N values, so the bench sweeps several exponents up to the maximum. A sequencer that is off by one state moves `scl_hi` and the phase pulses to the wrong tick within one SCL period. A hold that fails to freeze shows as a tick arriving earlier than the clock count that includes the held cycles.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    localparam int M_BITS   = 4;
    localparam int N_BITS   = 3;
    localparam int SUB_PER  = 10;

    // Decoded sequence marks, one bit per quarter event.
    typedef struct packed {
        logic low_mid;
        logic rise;
        logic high_mid;
        logic fall;
    } phase_marks_t;
endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           run,
    input  logic [M_W-1:0] m_val,
    output logic           wrap
);
    typedef struct packed {
        logic [M_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (st_q.cnt == m_val) begin
                st_d.cnt = '0;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scl_pow2_stage.sv
module scl_pow2_stage #(
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic [N_W-1:0] n_val,
    output logic           wrap
);
    localparam int C_W = 1 << N_W;

    typedef struct packed {
        logic [C_W-1:0] cnt;
    } p2_st_t;

    p2_st_t         st_d, st_q;
    logic [C_W-1:0] limit;

    // Terminal count is 2^(n+1)-1: a mask with the low n+1 bits set.
    for (genvar i = 0; i < C_W; i++) begin : g_lim
        assign limit[i] = (n_val >= N_W'(i));
    end

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt == limit) begin
                st_d.cnt = '0;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_div_pkg::*;
#(
    parameter int SUBPH = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic sub_tick,
    output logic scl_hi,
    output logic ph_low_mid,
    output logic ph_rise,
    output logic ph_high_mid,
    output logic ph_fall
);
    localparam int SP_W = $clog2(SUBPH);
    localparam logic [SP_W-1:0] SP_LAST  = SP_W'(SUBPH - 1);
    localparam logic [SP_W-1:0] SP_RISE  = SP_W'(SUBPH / 2);
    localparam logic [SP_W-1:0] SP_LMID  = SP_W'(SUBPH / 5);
    localparam logic [SP_W-1:0] SP_HMID  = SP_W'(SUBPH / 2 + SUBPH / 5);

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic            tick;
        logic            hi;
        phase_marks_t    marks;
    } seq_st_t;

    seq_st_t         st_d, st_q;
    logic [SP_W-1:0] nsp;

    always_comb begin
        st_d       = st_q;
        st_d.tick  = 1'b0;
        st_d.marks = '0;
        nsp        = (st_q.sp == SP_LAST) ? '0 : st_q.sp + 1'b1;
        if (clr) begin
            st_d = '0;
        end else if (adv) begin
            st_d.sp             = nsp;
            st_d.tick           = 1'b1;
            st_d.hi             = (nsp >= SP_RISE);
            st_d.marks.low_mid  = (nsp == SP_LMID);
            st_d.marks.rise     = (nsp == SP_RISE);
            st_d.marks.high_mid = (nsp == SP_HMID);
            st_d.marks.fall     = (nsp == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sub_tick    = st_q.tick;
    assign scl_hi      = st_q.hi;
    assign ph_low_mid  = st_q.marks.low_mid;
    assign ph_rise     = st_q.marks.rise;
    assign ph_high_mid = st_q.marks.high_mid;
    assign ph_fall     = st_q.marks.fall;
endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div
    import scl_div_pkg::*;
#(
    parameter int M_W   = M_BITS,
    parameter int N_W   = N_BITS,
    parameter int SUBPH = SUB_PER
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               baud_we,
    input  logic [M_W+N_W-1:0] baud_wdata,
    input  logic               scl_hold,
    output logic               sub_tick,
    output logic               scl_hi,
    output logic               ph_low_mid,
    output logic               ph_rise,
    output logic               ph_high_mid,
    output logic               ph_fall
);
    localparam int B_W = M_W + N_W;

    logic [B_W-1:0] baud_d, baud_q;
    logic           restart, run, pre_wrap, p2_wrap;

    always_comb begin
        baud_d  = baud_we ? baud_wdata : baud_q;
        restart = baud_we | ~en;
        run     = ~restart & ~scl_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) baud_q <= '0;
        else        baud_q <= baud_d;
    end

    scl_prescale #(.M_W(M_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .run   (run),
        .m_val (baud_q[B_W-1:N_W]),
        .wrap  (pre_wrap)
    );

    scl_pow2_stage #(.N_W(N_W)) u_p2 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .step  (pre_wrap),
        .n_val (baud_q[N_W-1:0]),
        .wrap  (p2_wrap)
    );

    scl_phase_seq #(.SUBPH(SUBPH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (restart),
        .adv         (p2_wrap),
        .sub_tick    (sub_tick),
        .scl_hi      (scl_hi),
        .ph_low_mid  (ph_low_mid),
        .ph_rise     (ph_rise),
        .ph_high_mid (ph_high_mid),
        .ph_fall     (ph_fall)
    );
endmodule

// File: rtl/scl_rate_div_chk.sv
module scl_rate_div_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic baud_we,
    input logic scl_hold,
    input logic sub_tick,
    input logic scl_hi,
    input logic ph_low_mid,
    input logic ph_rise,
    input logic ph_high_mid,
    input logic ph_fall
);
    logic [3:0] marks;
    assign marks = {ph_low_mid, ph_rise, ph_high_mid, ph_fall};

    // R6
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_we |=> (!sub_tick && !scl_hi && marks == 4'b0));

    // R7
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sub_tick && !scl_hi && marks == 4'b0));

    // R8
    hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && en && !baud_we) |=> (!sub_tick && $stable(scl_hi)));

    // R5
    one_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(marks));

    // R5
    mark_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (marks != 4'b0) |-> sub_tick);

    // R4
    rise_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hi) |-> ph_rise);

    // R4
    fall_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_hi) |-> (ph_fall || $past(baud_we || !en)));
endmodule

bind scl_rate_div scl_rate_div_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .baud_we     (baud_we),
    .scl_hold    (scl_hold),
    .sub_tick    (sub_tick),
    .scl_hi      (scl_hi),
    .ph_low_mid  (ph_low_mid),
    .ph_rise     (ph_rise),
    .ph_high_mid (ph_high_mid),
    .ph_fall     (ph_fall)
);

// File: tb/scl_rate_div_test.sv
module scl_rate_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       baud_we = 1'b0;
    logic [6:0] baud_wdata = '0;
    logic       scl_hold = 1'b0;
    logic       sub_tick, scl_hi, ph_low_mid, ph_rise, ph_high_mid, ph_fall;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    scl_rate_div uut (
        .clk(clk), .rst_n(rst_n), .en(en), .baud_we(baud_we),
        .baud_wdata(baud_wdata), .scl_hold(scl_hold), .sub_tick(sub_tick),
        .scl_hi(scl_hi), .ph_low_mid(ph_low_mid), .ph_rise(ph_rise),
        .ph_high_mid(ph_high_mid), .ph_fall(ph_fall)
    );

    // Baud values and the clocks per sub-phase, (M+1)*2^(N+1).
    localparam int NV = 7;
    localparam logic [6:0] BAUD_TAB [NV] = '{7'h00, 7'h08, 7'h01, 7'h13, 7'h3A, 7'h47, 7'h7F};
    localparam int         RAT_TAB  [NV] = '{2, 4, 4, 48, 64, 2304, 4096};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_baud(input logic [6:0] v);
        @(negedge clk);
        baud_we = 1'b1;
        baud_wdata = v;
        @(negedge clk);
        baud_we = 1'b0;
    endtask

    task automatic to_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sub_tick && n < 10000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int k;
        int exp_sp;
        logic [3:0] mk;
        logic [3:0] exp_mk;

        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk({sub_tick, scl_hi, ph_low_mid, ph_rise, ph_high_mid, ph_fall} == 6'b0,
            "R1 in reset", int'(scl_hi), 0);
        rst_n = 1'b1;
        en    = 1'b1;
        @(negedge clk);
        chk(!sub_tick && !scl_hi, "R1 after reset", int'(sub_tick), 0);
        // R1: reset baud gives 2 clocks per sub-phase (counting from reset release)
        to_tick(n);
        to_tick(n);
        chk(n == 2, "R1 reset ratio", n, 2);

        // R2/R3/R9: table walk
        for (int i = 0; i < NV; i++) begin
            write_baud(BAUD_TAB[i]);
            chk(!scl_hi && !sub_tick, "R6 cleared after write", int'(scl_hi), 0);
            to_tick(n);
            chk(n == RAT_TAB[i], "R3 first tick", n, RAT_TAB[i]);
            to_tick(n);
            chk(n == RAT_TAB[i], (i == NV - 1) ? "R9 max spacing" : "R2 spacing", n, RAT_TAB[i]);
        end

        // R4/R5: full period sequence at ratio 4
        write_baud(7'h08);
        for (k = 1; k <= 12; k++) begin
            to_tick(n);
            exp_sp = k % 10;
            chk(n == 4, "R2 period in sequence", n, 4);
            chk(scl_hi == (exp_sp >= 5), "R4 scl level", int'(scl_hi), int'(exp_sp >= 5));
            mk     = {ph_low_mid, ph_rise, ph_high_mid, ph_fall};
            exp_mk = {exp_sp == 2, exp_sp == 5, exp_sp == 7, exp_sp == 0};
            chk(mk == exp_mk, "R5 phase marks", int'(mk), int'(exp_mk));
        end

        // R6: restart in the high half
        write_baud(7'h08);
        for (k = 0; k < 6; k++) to_tick(n);
        chk(scl_hi == 1'b1, "R4 high before restart", int'(scl_hi), 1);
        write_baud(7'h08);
        chk(!scl_hi, "R6 restart drops level", int'(scl_hi), 0);
        to_tick(n);
        chk(n == 4 && !scl_hi, "R6 restart timing", n, 4);

        // R7: disabled stays idle, then restarts
        @(negedge clk);
        en = 1'b0;
        k = 0;
        repeat (40) begin
            @(negedge clk);
            if (sub_tick || scl_hi) k++;
        end
        chk(k == 0, "R7 idle while disabled", k, 0);
        en = 1'b1;
        to_tick(n);
        chk(n == 4, "R7 restart after enable", n, 4);

        // R8: hold at the start delays the first tick
        write_baud(7'h00);
        scl_hold = 1'b1;
        k = 0;
        repeat (5) begin
            @(negedge clk);
            if (sub_tick) k++;
        end
        scl_hold = 1'b0;
        to_tick(n);
        chk(k == 0 && n + 5 == 7, "R8 hold delays tick", n + 5, 7);

        // R8: hold in the high half keeps the level
        write_baud(7'h00);
        for (k = 0; k < 5; k++) to_tick(n);
        scl_hold = 1'b1;
        k = 0;
        repeat (20) begin
            @(negedge clk);
            if (sub_tick || !scl_hi) k++;
        end
        scl_hold = 1'b0;
        chk(k == 0, "R8 frozen high", k, 0);
        to_tick(n);
        chk(n == 2 && scl_hi, "R8 resume spacing", n, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule